// File: doc/BRIEF.md
# 16-bit Effective-Address Decoder

This block turns the addressing-form byte of a memory operand, under 16-bit address size, into an offset. The byte carries a two-bit mode field in bits 7:6 and a three-bit base selector in bits 2:0. Bits 5:3 are not used. The two instruction bytes that follow the form byte are presented alongside it as a displacement candidate. A snapshot of the four address registers is also supplied (base X, base pointer, source index, destination index). From these the block builds the offset, counts how many displacement bytes the form consumes, flags forms that cannot address memory, and picks the segment the access defaults to.

A caller pulses `startIn` for one cycle with all inputs valid. One clock later the result appears with a one-cycle `resValid` strobe and is held until the next start. Segment translation, limit checks and 32-bit address forms belong to other blocks.

Top module: `ea16_decode`

## Requirements
- R1: For mode 0 (with base selector other than 6), mode 1 and mode 2, the base selector picks the register sum as follows: 0 is X+SI, 1 is X+DI, 2 is BP+SI, 3 is BP+DI, 4 is SI, 5 is DI, 6 is BP and 7 is X. Mode 0 adds no displacement and reports a count of 0.
- R2: Mode 0 with base selector 6 is a direct address. The offset is {dispHi, dispLo} with no register added, and the count is 2.
- R3: Mode 1 adds dispLo sign-extended from bit 7, and the count is 1.
- R4: Mode 2 adds the 16-bit displacement {dispHi, dispLo}, with dispLo as the low byte, and the count is 2. The count is never 3.
- R5: Mode 3 sets resInvalid. In that case the offset is 0 and the count is 0.
- R6: If ovrValid is 1, resSeg equals ovrSeg. Otherwise resSeg is stack (code 2) for base selectors 2, 3 and 6 in modes 0 to 2. It is data (code 3) for every other form, including the direct address and mode 3. The segment codes are extra 0, code 1, stack 2, data 3, fourth 4, fifth 5.
- R7: Only the low 16 bits of each register take part. The sum wraps modulo 2^16.
- R8: resValid is 1 exactly in the cycle after a cycle with startIn high. The result outputs change only in such cycles and hold otherwise.
- R9: After reset, resValid, resOffset, resCount and resInvalid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| startIn | input | 1 | One-cycle request strobe |
| formByte | input | 8 | Addressing-form byte (mode 7:6, base selector 2:0) |
| dispLo | input | 8 | First byte after the form byte (displacement low byte) |
| dispHi | input | 8 | Second byte after the form byte (displacement high byte) |
| regBx | input | REG_W | Base X register snapshot |
| regBp | input | REG_W | Base pointer register snapshot |
| regSi | input | REG_W | Source index register snapshot |
| regDi | input | REG_W | Destination index register snapshot |
| ovrValid | input | 1 | A segment override is present |
| ovrSeg | input | 3 | Override segment code |
| resValid | output | 1 | Result strobe |
| resOffset | output | ADDR_W | Computed 16-bit offset |
| resCount | output | 2 | Displacement bytes consumed (0, 1 or 2) |
| resInvalid | output | 1 | Form cannot address memory |
| resSeg | output | 3 | Effective segment code |

## Verification
All 256 form bytes are swept against four register snapshots, each with and without an override. This covers every mode and selector pairing.

- A snapshot of distinct small values shows which registers each selector adds.
- A snapshot of all zeros isolates the displacement path.
- Near-overflow values show the 16-bit wraparound.
- Values carrying upper bits show that only the low half is used.
- Displacement bytes follow the form byte, so both signs of the 8-bit displacement appear.
- Toggling the override separates the stack-promotion rule from pass-through.

A separate idle step changes every input without a start to show that the outputs hold.

// File: rtl/ea16_pkg.sv
package ea16_pkg;

  typedef enum logic [2:0] {
    SEG_EXTRA  = 3'd0,
    SEG_CODE   = 3'd1,
    SEG_STACK  = 3'd2,
    SEG_DATA   = 3'd3,
    SEG_FOURTH = 3'd4,
    SEG_FIFTH  = 3'd5
  } segCode_t;

  // displacement kind doubles as the consumed byte count
  typedef enum logic [1:0] {
    DISP_NONE = 2'd0,
    DISP_BYTE = 2'd1,
    DISP_WORD = 2'd2
  } dispKind_t;

  typedef struct packed {
    logic      load;
    logic      useBx;
    logic      useBp;
    logic      useSi;
    logic      useDi;
    dispKind_t dispKind;
    logic      stackDflt;
    logic      invalid;
  } eaCtrl_t;

endpackage

// File: rtl/ea16_ctrl.sv
module ea16_ctrl
  import ea16_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       startIn,
  input  logic [7:0] formByte,
  output eaCtrl_t    ctrl,
  output logic       resValid
);

  logic [1:0] mode;
  logic [2:0] rm;
  logic [2:0] unusedOpField;

  assign mode          = formByte[7:6];
  assign rm            = formByte[2:0];
  assign unusedOpField = formByte[5:3];

  always_comb begin
    ctrl          = '0;
    ctrl.load     = startIn;
    ctrl.dispKind = DISP_NONE;
    if (mode == 2'd3) begin
      ctrl.invalid = 1'b1;
    end else begin
      unique case (rm)
        3'd0: begin ctrl.useBx = 1'b1; ctrl.useSi = 1'b1; end
        3'd1: begin ctrl.useBx = 1'b1; ctrl.useDi = 1'b1; end
        3'd2: begin ctrl.useBp = 1'b1; ctrl.useSi = 1'b1; ctrl.stackDflt = 1'b1; end
        3'd3: begin ctrl.useBp = 1'b1; ctrl.useDi = 1'b1; ctrl.stackDflt = 1'b1; end
        3'd4: ctrl.useSi = 1'b1;
        3'd5: ctrl.useDi = 1'b1;
        3'd6: begin ctrl.useBp = 1'b1; ctrl.stackDflt = 1'b1; end
        default: ctrl.useBx = 1'b1;
      endcase
      unique case (mode)
        2'd1:    ctrl.dispKind = DISP_BYTE;
        2'd2:    ctrl.dispKind = DISP_WORD;
        default: ctrl.dispKind = DISP_NONE;
      endcase
      // direct address form: word displacement only, no stack promotion
      if (mode == 2'd0 && rm == 3'd6) begin
        ctrl.useBp     = 1'b0;
        ctrl.stackDflt = 1'b0;
        ctrl.dispKind  = DISP_WORD;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) resValid <= 1'b0;
    else     resValid <= startIn;
  end

  // R5: an illegal form never selects a register
  assert_invalid_no_regs_R5: assert property (@(posedge clk) disable iff (rst)
    (startIn && mode == 2'd3) |-> !(ctrl.useBx || ctrl.useBp || ctrl.useSi || ctrl.useDi));

endmodule

// File: rtl/ea16_dp.sv
module ea16_dp
  import ea16_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  eaCtrl_t           ctrl,
  input  logic [7:0]        dispLo,
  input  logic [7:0]        dispHi,
  input  logic [REG_W-1:0]  regBx,
  input  logic [REG_W-1:0]  regBp,
  input  logic [REG_W-1:0]  regSi,
  input  logic [REG_W-1:0]  regDi,
  input  logic              ovrValid,
  input  logic [2:0]        ovrSeg,
  output logic [ADDR_W-1:0] resOffset,
  output logic [1:0]        resCount,
  output logic              resInvalid,
  output logic [2:0]        resSeg
);

  localparam int SEXT_W = ADDR_W - 8;

  logic [ADDR_W-1:0] bxLow, bpLow, siLow, diLow;
  logic [ADDR_W-1:0] dispVal, sumNext;
  logic [2:0]        segNext;

  generate
    if (REG_W > ADDR_W) begin : g_trunc
      logic unusedHigh;
      assign unusedHigh = ^{regBx[REG_W-1:ADDR_W], regBp[REG_W-1:ADDR_W],
                            regSi[REG_W-1:ADDR_W], regDi[REG_W-1:ADDR_W]};
      assign bxLow = regBx[ADDR_W-1:0];
      assign bpLow = regBp[ADDR_W-1:0];
      assign siLow = regSi[ADDR_W-1:0];
      assign diLow = regDi[ADDR_W-1:0];
    end else begin : g_widen
      assign bxLow = ADDR_W'(regBx);
      assign bpLow = ADDR_W'(regBp);
      assign siLow = ADDR_W'(regSi);
      assign diLow = ADDR_W'(regDi);
    end
  endgenerate

  always_comb begin
    unique case (ctrl.dispKind)
      DISP_BYTE: dispVal = {{SEXT_W{dispLo[7]}}, dispLo};
      DISP_WORD: dispVal = ADDR_W'({dispHi, dispLo});
      default:   dispVal = '0;
    endcase
  end

  always_comb begin
    sumNext = dispVal;
    if (ctrl.useBx) sumNext = sumNext + bxLow;
    if (ctrl.useBp) sumNext = sumNext + bpLow;
    if (ctrl.useSi) sumNext = sumNext + siLow;
    if (ctrl.useDi) sumNext = sumNext + diLow;
  end

  always_comb begin
    if (ovrValid)            segNext = ovrSeg;
    else if (ctrl.stackDflt) segNext = SEG_STACK;
    else                     segNext = SEG_DATA;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resOffset  <= '0;
      resCount   <= '0;
      resInvalid <= 1'b0;
      resSeg     <= SEG_DATA;
    end else if (ctrl.load) begin
      resOffset  <= sumNext;
      resCount   <= ctrl.dispKind;
      resInvalid <= ctrl.invalid;
      resSeg     <= segNext;
    end
  end

  // R8: without a load the result registers keep their value
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !ctrl.load |=> ($stable(resOffset) && $stable(resCount) && $stable(resSeg)));

  // R4: the consumed count never reaches 3
  assert_count_range_R4: assert property (@(posedge clk) disable iff (rst)
    resCount != 2'd3);

endmodule

// File: rtl/ea16_decode.sv
module ea16_decode
  import ea16_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              startIn,
  input  logic [7:0]        formByte,
  input  logic [7:0]        dispLo,
  input  logic [7:0]        dispHi,
  input  logic [REG_W-1:0]  regBx,
  input  logic [REG_W-1:0]  regBp,
  input  logic [REG_W-1:0]  regSi,
  input  logic [REG_W-1:0]  regDi,
  input  logic              ovrValid,
  input  logic [2:0]        ovrSeg,
  output logic              resValid,
  output logic [ADDR_W-1:0] resOffset,
  output logic [1:0]        resCount,
  output logic              resInvalid,
  output logic [2:0]        resSeg
);

  eaCtrl_t ctrl;

  ea16_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .startIn  (startIn),
    .formByte (formByte),
    .ctrl     (ctrl),
    .resValid (resValid)
  );

  ea16_dp #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .ctrl       (ctrl),
    .dispLo     (dispLo),
    .dispHi     (dispHi),
    .regBx      (regBx),
    .regBp      (regBp),
    .regSi      (regSi),
    .regDi      (regDi),
    .ovrValid   (ovrValid),
    .ovrSeg     (ovrSeg),
    .resOffset  (resOffset),
    .resCount   (resCount),
    .resInvalid (resInvalid),
    .resSeg     (resSeg)
  );

  // R5: an invalid result carries no offset and no consumed bytes
  assert_invalid_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (resValid && resInvalid) |-> (resOffset == '0 && resCount == 2'd0));

  // R8: a result strobe only follows a request
  assert_valid_after_start_R8: assert property (@(posedge clk) disable iff (rst)
    resValid |-> $past(startIn));

  // R6: the direct form without override stays on the data segment
  assert_direct_data_seg_R6: assert property (@(posedge clk) disable iff (rst)
    (resValid && $past(formByte) == 8'h06 && !$past(ovrValid)) |-> resSeg == SEG_DATA);

endmodule

// File: tb/ea16_decode_bench.sv
module ea16_decode_bench;

  localparam int REG_W  = 32;
  localparam int ADDR_W = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              startIn = 1'b0;
  logic [7:0]        formByte = '0, dispLo = '0, dispHi = '0;
  logic [REG_W-1:0]  regBx = '0, regBp = '0, regSi = '0, regDi = '0;
  logic              ovrValid = 1'b0;
  logic [2:0]        ovrSeg = '0;
  logic              resValid;
  logic [ADDR_W-1:0] resOffset;
  logic [1:0]        resCount;
  logic              resInvalid;
  logic [2:0]        resSeg;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  ea16_decode #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_ea16_decode (
    .clk(clk), .rst(rst), .startIn(startIn), .formByte(formByte),
    .dispLo(dispLo), .dispHi(dispHi), .regBx(regBx), .regBp(regBp),
    .regSi(regSi), .regDi(regDi), .ovrValid(ovrValid), .ovrSeg(ovrSeg),
    .resValid(resValid), .resOffset(resOffset), .resCount(resCount),
    .resInvalid(resInvalid), .resSeg(resSeg)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pickReg(input int setIdx, input int which);
    logic [31:0] v [4][4];
    v[0] = '{32'h0000_1234, 32'h0000_0F00, 32'h0000_0011, 32'h0000_2200};
    v[1] = '{32'h0000_FFFF, 32'h0000_8000, 32'h0000_8001, 32'h0000_7FFF};
    v[2] = '{32'h0, 32'h0, 32'h0, 32'h0};
    v[3] = '{32'hABCD_F000, 32'h1234_0FFF, 32'hFFFF_0010, 32'h0001_FFFE};
    return v[setIdx][which];
  endfunction

  task automatic applyVector(input int setIdx, input int ovr, input int f);
    int mode, rm, bx, bp, si, di, base, disp, expOff, expCnt, expInv, expSeg;
    logic [7:0] lo, hi;
    string tag;
    lo = 8'(f ^ (setIdx * 8'h37));
    hi = 8'(~f + setIdx);
    formByte = 8'(f); dispLo = lo; dispHi = hi;
    regBx = pickReg(setIdx, 0); regBp = pickReg(setIdx, 1);
    regSi = pickReg(setIdx, 2); regDi = pickReg(setIdx, 3);
    ovrValid = ovr[0];
    case ((f + setIdx) % 4)
      0: ovrSeg = 3'd0;
      1: ovrSeg = 3'd1;
      2: ovrSeg = 3'd4;
      default: ovrSeg = 3'd5;
    endcase
    startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    mode = (f >> 6) & 3; rm = f & 7;
    bx = regBx & 32'hFFFF; bp = regBp & 32'hFFFF;
    si = regSi & 32'hFFFF; di = regDi & 32'hFFFF;
    case (rm)
      0: base = bx + si; 1: base = bx + di; 2: base = bp + si; 3: base = bp + di;
      4: base = si;      5: base = di;      6: base = bp;      default: base = bx;
    endcase
    expInv = 0; disp = 0; expCnt = 0;
    if (mode == 3) begin
      expInv = 1; base = 0; tag = "R5";
    end else if (mode == 0 && rm == 6) begin
      base = 0; disp = {hi, lo}; expCnt = 2; tag = "R2";
    end else if (mode == 1) begin
      disp = {{24{lo[7]}}, lo}; expCnt = 1; tag = "R3";
    end else if (mode == 2) begin
      disp = {hi, lo}; expCnt = 2; tag = "R4";
    end else begin
      tag = "R1";
    end
    if (setIdx == 3 && mode != 3) tag = "R7";
    expOff = (base + disp) & 32'hFFFF;
    if (ovr != 0) expSeg = ovrSeg;
    else if (mode != 3 && !(mode == 0 && rm == 6) && (rm == 2 || rm == 3 || rm == 6)) expSeg = 2;
    else expSeg = 3;
    check("R8", "valid", int'(resValid), 1);
    check(tag, "offset", int'(resOffset), expOff);
    check(tag, "count", int'(resCount), expCnt);
    check("R5", "invalid", int'(resInvalid), expInv);
    check("R6", "segment", int'(resSeg), expSeg);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int keepOff, keepSeg, keepCnt;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9", "valid", int'(resValid), 0);
    check("R9", "offset", int'(resOffset), 0);
    check("R9", "count", int'(resCount), 0);
    check("R9", "invalid", int'(resInvalid), 0);
    rst = 1'b0;
    @(negedge clk);
    for (int s = 0; s < 4; s++)
      for (int o = 0; o < 2; o++)
        for (int f = 0; f < 256; f++)
          applyVector(s, o, f);
    // R8: idle cycles with changed inputs leave the result untouched
    keepOff = int'(resOffset); keepSeg = int'(resSeg); keepCnt = int'(resCount);
    formByte = 8'h86; dispLo = 8'h55; dispHi = 8'hAA;
    regBx = 32'h1111; regBp = 32'h2222; regSi = 32'h3333; regDi = 32'h4444;
    ovrValid = 1'b0;
    @(negedge clk);
    check("R8", "idle valid", int'(resValid), 0);
    @(negedge clk);
    check("R8", "idle offset", int'(resOffset), keepOff);
    check("R8", "idle segment", int'(resSeg), keepSeg);
    check("R8", "idle count", int'(resCount), keepCnt);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule